// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches one 16-bit word from a three-wire serial EEPROM. It generates the chip select, the shift clock and the serial data going to the memory, and it samples the serial data coming back. A single-cycle start request carries a word address and an address-width choice. The block then sends a read command made of a start bit, a two-bit read opcode and the address. It clocks in sixteen data bits, ends the access and reports the word with a one-cycle done pulse.

The memory may take either a 6-bit or an 8-bit word address. A detect request reads word 0 with the 8-bit width. If that word equals the 8-bit-part signature 0x8129, the block records that the part is wide; otherwise it records narrow. Later reads can then either follow that recorded width or take the width from an input pin. A divider input sets how many system clock cycles each low and high phase of the shift clock lasts.

Top module: `mw_eeprom_reader`

## Requirements
- R1: After reset, cs_o, sk_o, sdi_o, done_o, busy_o and wide_o are 0 and data_o is all zeros.
- R2: A read sends 3+W command bits MSB first: a 1 start bit, then opcode bits 1 and 0, then the W-bit address. W is 8 when the width in use is wide and 6 when it is narrow, and for 6-bit reads the upper address bits are ignored. The width in use is 8 for a detect run, wide_o when auto_w_i=1, and otherwise wide_i (1 = 8 bits).
- R3: Each command bit is placed on sdi_o when sk_o goes low and is held through the following high phase.
- R4: After the command and one idle low phase, sk_o pulses 16 times. sdo_i is sampled in the last cycle of each high phase, and the bits form data_o MSB first.
- R5: cs_o stays low for one phase after the request, then rises one phase before the first command clock, and falls after the 16th data clock. sk_o is never high while cs_o is low, and cs_o rises exactly once per access.
- R6: Every high phase of sk_o lasts exactly D system cycles and every low phase with cs_o high lasts at least D cycles. D is div_i taken when the request is accepted, and 0 counts as 1.
- R7: done_o is high for exactly one cycle, (42+2W)·D+1 cycles counted from the cycle in which the request is given. data_o changes only in the done cycle and holds its value until the next done.
- R8: A start_i request while busy_o is high is ignored. The running access is not changed, and no extra access or done follows.
- R9: A start with detect_i=1 reads word 0 with the 8-bit width, returns it on data_o, and sets wide_o in the done cycle: to 1 if the word is 0x8129, otherwise to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to begin an access |
| addr_i | input | 8 | Word address; only the low 6 bits are used at narrow width |
| wide_i | input | 1 | Width pin: 1 = 8-bit address, 0 = 6-bit |
| auto_w_i | input | 1 | 1 = use the detected width in place of wide_i |
| detect_i | input | 1 | With start_i: run the width detection on word 0 |
| div_i | input | 8 | Length of each shift-clock phase in cycles (0 treated as 1) |
| sdo_i | input | 1 | Serial data from the memory |
| cs_o | output | 1 | Chip select to the memory |
| sk_o | output | 1 | Shift clock to the memory |
| sdi_o | output | 1 | Serial data to the memory |
| data_o | output | 16 | Last word read |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | An access is in progress |
| wide_o | output | 1 | Detected width: 1 = 8-bit part |

## Verification
Counted from the cycle in which the request is given, done_o and data_o are due (42+2W)·D+1 cycles later. The bench stamps each request with a free-running cycle count and compares the elapsed count when the done pulse appears, and it checks that done_o is low again one cycle later. The command bits and the 16 data clocks are judged at the memory pins: a bench memory model latches sdi_o on each rising sk_o edge and answers with a bench-computed word, so the command and the returned data are checked when done arrives. Phase lengths are measured at the falling clock edge, and wide_o is checked in the done cycle of each detect run.

// File: rtl/mw_pkg.sv
package mw_pkg;

   // Command opcodes, leading start bit included
   localparam logic [2:0] OPC_READ  = 3'b110;
   localparam logic [2:0] OPC_WRITE = 3'b101;
   localparam logic [2:0] OPC_ERASE = 3'b111;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CS_LO,
      ST_CS_HI,
      ST_CMD_LO,
      ST_CMD_HI,
      ST_GAP,
      ST_RD_HI,
      ST_RD_LO,
      ST_FIN
   } mw_state_e;

endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             run_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= DIV_W'(1);
         cnt_q <= '0;
      end else if (load_i) begin
         div_q <= (div_i == '0) ? DIV_W'(1) : div_i;
         cnt_q <= '0;
      end else if (!run_i || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   assign tick_o = run_i && (cnt_q == div_q - DIV_W'(1));

endmodule

// File: rtl/mw_cmd_build.sv
module mw_cmd_build import mw_pkg::*; #(
   parameter int ADDR_HI = 8,
   parameter int ADDR_LO = 6,
   parameter int CMD_W   = 3 + ADDR_HI,
   parameter int LENW    = $clog2(CMD_W + 1)
) (
   input  logic [ADDR_HI-1:0] addr_i,
   input  logic               wide_i,
   output logic [CMD_W-1:0]   cmd_o,
   output logic [LENW-1:0]    len_o
);
   localparam int PAD = ADDR_HI - ADDR_LO;

   logic [CMD_W-1:0] cmd_wide;
   logic [CMD_W-1:0] cmd_narrow;

   assign cmd_wide = {OPC_READ, addr_i};

   generate
      if (PAD == 0) begin : g_same
         assign cmd_narrow = cmd_wide;
      end else begin : g_pad
         assign cmd_narrow = {OPC_READ, addr_i[ADDR_LO-1:0], {PAD{1'b0}}};
      end
   endgenerate

   assign cmd_o = wide_i ? cmd_wide : cmd_narrow;
   assign len_o = wide_i ? LENW'(3 + ADDR_HI) : LENW'(3 + ADDR_LO);

endmodule

// File: rtl/mw_width_det.sv
module mw_width_det #(
   parameter int          DATA_W = 16,
   parameter logic [15:0] SIG    = 16'h8129,
   parameter bit          EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic [DATA_W-1:0] word_i,
   output logic              wide_o
);
   generate
      if (EN) begin : g_det
         logic wide_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         wide_q <= 1'b0;
            else if (capture_i) wide_q <= (word_i == DATA_W'(SIG));
         end
         assign wide_o = wide_q;
      end else begin : g_nodet
         logic unused_in;
         assign unused_in = ^{clk, rst_n, capture_i, word_i};
         assign wide_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/mw_shift_seq.sv
module mw_shift_seq import mw_pkg::*; #(
   parameter int DATA_W = 16,
   parameter int CMD_W  = 11,
   parameter int LENW   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic [CMD_W-1:0]  cmd_i,
   input  logic [LENW-1:0]   len_i,
   input  logic              tick_i,
   input  logic              sdo_i,
   output logic              cs_o,
   output logic              sk_o,
   output logic              sdi_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              fin_o,
   output logic [DATA_W-1:0] shift_o,
   output logic [DATA_W-1:0] data_o
);
   localparam int MAXB = (CMD_W > DATA_W) ? CMD_W : DATA_W;
   localparam int BCW  = $clog2(MAXB);

   mw_state_e         st_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [BCW-1:0]    bcnt_q;
   logic [DATA_W-1:0] dsh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cmd_q  <= '0;
         bcnt_q <= '0;
         dsh_q  <= '0;
         done_o <= 1'b0;
         data_o <= '0;
      end else begin
         done_o <= 1'b0;
         if (st_q == ST_IDLE) begin
            if (accept_i) begin
               st_q   <= ST_CS_LO;
               cmd_q  <= cmd_i;
               bcnt_q <= BCW'(len_i) - BCW'(1);
            end
         end else if (tick_i) begin
            unique case (st_q)
               ST_CS_LO:  st_q <= ST_CS_HI;
               ST_CS_HI:  st_q <= ST_CMD_LO;
               ST_CMD_LO: st_q <= ST_CMD_HI;
               ST_CMD_HI: begin
                  if (bcnt_q == '0) begin
                     st_q   <= ST_GAP;
                     bcnt_q <= BCW'(DATA_W - 1);
                  end else begin
                     st_q   <= ST_CMD_LO;
                     bcnt_q <= bcnt_q - BCW'(1);
                     cmd_q  <= {cmd_q[CMD_W-2:0], 1'b0};
                  end
               end
               ST_GAP:    st_q <= ST_RD_HI;
               ST_RD_HI: begin
                  dsh_q <= {dsh_q[DATA_W-2:0], sdo_i};
                  st_q  <= ST_RD_LO;
               end
               ST_RD_LO: begin
                  if (bcnt_q == '0) begin
                     st_q <= ST_FIN;
                  end else begin
                     bcnt_q <= bcnt_q - BCW'(1);
                     st_q   <= ST_RD_HI;
                  end
               end
               ST_FIN: begin
                  st_q   <= ST_IDLE;
                  done_o <= 1'b1;
                  data_o <= dsh_q;
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      cs_o  = 1'b0;
      sk_o  = 1'b0;
      sdi_o = 1'b0;
      unique case (st_q)
         ST_CS_HI, ST_GAP, ST_RD_LO: cs_o = 1'b1;
         ST_CMD_LO: begin
            cs_o  = 1'b1;
            sdi_o = cmd_q[CMD_W-1];
         end
         ST_CMD_HI: begin
            cs_o  = 1'b1;
            sk_o  = 1'b1;
            sdi_o = cmd_q[CMD_W-1];
         end
         ST_RD_HI: begin
            cs_o = 1'b1;
            sk_o = 1'b1;
         end
         default: ;
      endcase
   end

   assign busy_o  = (st_q != ST_IDLE);
   assign fin_o   = (st_q == ST_FIN) && tick_i;
   assign shift_o = dsh_q;

endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader import mw_pkg::*; #(
   parameter int          DATA_W  = 16,
   parameter int          ADDR_HI = 8,
   parameter int          ADDR_LO = 6,
   parameter int          DIV_W   = 8,
   parameter logic [15:0] SIG     = 16'h8129,
   parameter bit          EN_DET  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [ADDR_HI-1:0] addr_i,
   input  logic               wide_i,
   input  logic               auto_w_i,
   input  logic               detect_i,
   input  logic [DIV_W-1:0]   div_i,
   input  logic               sdo_i,
   output logic               cs_o,
   output logic               sk_o,
   output logic               sdi_o,
   output logic [DATA_W-1:0]  data_o,
   output logic               done_o,
   output logic               busy_o,
   output logic               wide_o
);
   localparam int CMD_W = 3 + ADDR_HI;
   localparam int LENW  = $clog2(CMD_W + 1);

   generate
      if (ADDR_HI < ADDR_LO) begin : g_bad_addr
         $error("ADDR_HI must not be below ADDR_LO");
      end
      if (DATA_W < 2 || DATA_W > 16) begin : g_bad_data
         $error("DATA_W must lie in 2..16");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
   endgenerate

   logic               accept;
   logic               use_wide;
   logic [ADDR_HI-1:0] use_addr;
   logic [CMD_W-1:0]   cmd;
   logic [LENW-1:0]    len;
   logic               tick;
   logic               fin;
   logic [DATA_W-1:0]  shift_word;
   logic               det_q;

   assign accept   = start_i && !busy_o;
   assign use_wide = detect_i ? 1'b1 : (auto_w_i ? wide_o : wide_i);
   assign use_addr = detect_i ? '0 : addr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      det_q <= 1'b0;
      else if (accept) det_q <= detect_i && EN_DET;
   end

   mw_cmd_build #(
      .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .CMD_W(CMD_W), .LENW(LENW)
   ) u_cmd (
      .addr_i(use_addr), .wide_i(use_wide), .cmd_o(cmd), .len_o(len)
   );

   mw_phase_timer #(.DIV_W(DIV_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load_i(accept), .div_i(div_i),
      .run_i(busy_o), .tick_o(tick)
   );

   mw_shift_seq #(.DATA_W(DATA_W), .CMD_W(CMD_W), .LENW(LENW)) u_seq (
      .clk(clk), .rst_n(rst_n), .accept_i(accept), .cmd_i(cmd), .len_i(len),
      .tick_i(tick), .sdo_i(sdo_i), .cs_o(cs_o), .sk_o(sk_o), .sdi_o(sdi_o),
      .busy_o(busy_o), .done_o(done_o), .fin_o(fin), .shift_o(shift_word),
      .data_o(data_o)
   );

   mw_width_det #(.DATA_W(DATA_W), .SIG(SIG), .EN(EN_DET)) u_det (
      .clk(clk), .rst_n(rst_n), .capture_i(fin && det_q),
      .word_i(shift_word), .wide_o(wide_o)
   );

endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk #(
   parameter int DATA_W = 16,
   parameter int DIV_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [DIV_W-1:0]  div_i,
   input logic              busy_o,
   input logic              cs_o,
   input logic              sk_o,
   input logic              sdi_o,
   input logic              done_o,
   input logic [DATA_W-1:0] data_o
);
   logic [DIV_W-1:0] div_lat;
   logic [DIV_W:0]   run_q;
   logic             sk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_lat <= DIV_W'(1);
         run_q   <= '0;
         sk_prev <= 1'b0;
      end else begin
         if (start_i && !busy_o) div_lat <= (div_i == '0) ? DIV_W'(1) : div_i;
         sk_prev <= sk_o;
         if (sk_o != sk_prev)   run_q <= (DIV_W+1)'(1);
         else if (~&run_q)      run_q <= run_q + (DIV_W+1)'(1);
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!cs_o && !sk_o && !sdi_o)); // R1

   AST_SDI_HELD_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (sk_o && sk_prev) |-> $stable(sdi_o)); // R3

   AST_SK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      sk_o |-> cs_o); // R5

   AST_HI_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (sk_prev && !sk_o) |-> (run_q >= {1'b0, div_lat})); // R6

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(data_o)); // R7

   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !done_o) |=> (busy_o || done_o)); // R8

endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_i(div_i), .busy_o(busy_o),
   .cs_o(cs_o), .sk_o(sk_o), .sdi_o(sdi_o), .done_o(done_o), .data_o(data_o)
);

// File: tb/tb_mw_eeprom_reader.sv
module tb_mw_eeprom_reader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  addr_i = '0;
   logic        wide_i = 1'b0;
   logic        auto_w_i = 1'b0;
   logic        detect_i = 1'b0;
   logic [7:0]  div_i = 8'd1;
   logic        sdo_i = 1'b0;
   logic        cs_o, sk_o, sdi_o, done_o, busy_o, wide_o;
   logic [15:0] data_o;

   always #5 clk = ~clk;

   mw_eeprom_reader dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
      .wide_i(wide_i), .auto_w_i(auto_w_i), .detect_i(detect_i), .div_i(div_i),
      .sdo_i(sdo_i), .cs_o(cs_o), .sk_o(sk_o), .sdi_o(sdi_o), .data_o(data_o),
      .done_o(done_o), .busy_o(busy_o), .wide_o(wide_o)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit ended  = 0;

   typedef struct {
      logic [15:0] data;
      logic [7:0]  addr;
      int          aw;
      int          issue;
      int          div;
      bit          det;
      bit          expw;
   } item_t;
   item_t q[$];

   bit sig_mode  = 0;
   int model_aw  = 6;
   int cur_div   = 1;
   bit det_state = 0;

   function automatic logic [15:0] word_of(input logic [7:0] a);
      if (a == 8'h00 && sig_mode) return 16'h8129;
      return {a, a ^ 8'hA5} ^ 16'h1234;
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) cyc++;

   // memory model at the pins
   logic [15:0] m_cmd = '0;
   logic [15:0] m_out = '0;
   int m_ncmd = 0, m_nrd = 0, m_csr = 0, m_fin_rd = 0;
   always @(posedge cs_o) begin
      m_cmd = '0; m_ncmd = 0; m_nrd = 0; m_csr++;
   end
   always @(negedge cs_o) m_fin_rd = m_nrd;
   always @(posedge sk_o) if (cs_o) begin
      if (m_ncmd < 3 + model_aw) begin
         m_cmd = {m_cmd[14:0], sdi_o};
         m_ncmd++;
         if (m_ncmd == 3 + model_aw)
            m_out = word_of(m_cmd[7:0] & ((model_aw == 8) ? 8'hFF : 8'h3F));
      end else if (m_nrd < 16) begin
         sdo_i = m_out[15 - m_nrd];
         m_nrd++;
      end
   end

   // phase length measurement
   int hr = 0, lr = 0, bad_ph = 0;
   always @(negedge clk) begin
      if (sk_o) begin
         if (lr != 0 && lr < cur_div) bad_ph++;
         lr = 0;
         hr++;
      end else begin
         if (hr != 0 && hr != cur_div) bad_ph++;
         hr = 0;
         if (cs_o) lr++; else lr = 0;
      end
   end

   // monitor / scoreboard
   bit pend_low = 0;
   always @(negedge clk) begin
      if (pend_low) begin
         chk("R7", "done width", {31'd0, done_o}, 32'd0);
         pend_low = 0;
      end
      if (done_o && rst_n) begin
         if (q.size() == 0) begin
            chk("R8", "done without request", 32'd1, 32'd0);
         end else begin
            item_t it;
            logic [15:0] ecmd;
            it = q.pop_front();
            ecmd = (16'd6 << it.aw) | {8'd0, it.addr};
            chk("R4", "data word", {16'd0, data_o}, {16'd0, it.data});
            chk("R2", "command bits", {16'd0, m_cmd}, {16'd0, ecmd});
            chk("R2", "command length", m_ncmd, 3 + it.aw);
            chk("R5", "data clocks before cs drop", m_fin_rd, 32'd16);
            chk("R5", "cs rises per access", m_csr, 32'd1);
            chk("R6", "phase length errors", bad_ph, 32'd0);
            chk("R7", "done latency", cyc - it.issue,
                (42 + 2 * it.aw) * it.div + 1);
            if (it.det) chk("R9", "detected width", {31'd0, wide_o}, {31'd0, it.expw});
            bad_ph = 0;
         end
         pend_low = 1;
      end
   end

   task automatic issue(input logic [7:0] a, input bit wide, input bit auto_w,
                        input bit det, input logic [7:0] dv, input bit intrude);
      item_t it;
      int aw;
      aw = det ? 8 : ((auto_w ? det_state : wide) ? 8 : 6);
      it.addr  = det ? 8'h00 : (aw == 8 ? a : (a & 8'h3F));
      it.aw    = aw;
      it.div   = (dv == 0) ? 1 : int'(dv);
      it.det   = det;
      sdo_i    = 1'b0;
      it.data  = word_of(it.addr);
      it.expw  = (it.data == 16'h8129);
      if (det) det_state = it.expw;
      @(negedge clk);
      model_aw = aw;
      cur_div  = it.div;
      m_csr    = 0;
      bad_ph   = 0;
      addr_i = a; wide_i = wide; auto_w_i = auto_w; detect_i = det; div_i = dv;
      start_i = 1'b1;
      it.issue = cyc;
      q.push_back(it);
      @(negedge clk);
      start_i = 1'b0; detect_i = 1'b0;
      if (intrude) begin
         repeat (5) @(negedge clk);
         addr_i = ~a; div_i = 8'd7; wide_i = ~wide; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (busy_o || q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] held;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "cs/sk/sdi", {29'd0, cs_o, sk_o, sdi_o}, 32'd0);
      chk("R1", "done/busy/wide", {29'd0, done_o, busy_o, wide_o}, 32'd0);
      chk("R1", "data", {16'd0, data_o}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "idle after reset", {30'd0, cs_o, busy_o}, 32'd0);

      issue(8'h15, 1'b0, 1'b0, 1'b0, 8'd1, 1'b0);   // R2 narrow
      issue(8'hA7, 1'b1, 1'b0, 1'b0, 8'd3, 1'b0);   // R2 wide, R6 div 3
      issue(8'h3F, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0);   // R6 div 0 as 1
      issue(8'hED, 1'b0, 1'b0, 1'b0, 8'd2, 1'b0);   // R2 upper bits ignored
      issue(8'h5C, 1'b1, 1'b0, 1'b0, 8'd4, 1'b0);   // R4 another pattern

      // R8 start while busy
      issue(8'h22, 1'b0, 1'b0, 1'b0, 8'd2, 1'b1);
      repeat (10) @(negedge clk);
      chk("R8", "busy after ignored start", {31'd0, busy_o}, 32'd0);
      chk("R8", "cs after ignored start", {31'd0, cs_o}, 32'd0);

      // R7 data hold
      held = data_o;
      addr_i = 8'hFF; wide_i = 1'b1; div_i = 8'd9;
      repeat (30) @(negedge clk);
      chk("R7", "data held", {16'd0, data_o}, {16'd0, held});

      // R9 detect with signature present
      sig_mode = 1;
      issue(8'h44, 1'b0, 1'b0, 1'b1, 8'd1, 1'b0);
      issue(8'hC3, 1'b0, 1'b1, 1'b0, 8'd2, 1'b0);  // R9 auto width wide
      chk("R9", "wide kept", {31'd0, wide_o}, 32'd1);

      // R9 detect with signature absent
      sig_mode = 0;
      issue(8'h00, 1'b1, 1'b0, 1'b1, 8'd2, 1'b0);
      chk("R9", "narrow detected", {31'd0, wide_o}, 32'd0);
      issue(8'hAD, 1'b1, 1'b1, 1'b0, 8'd1, 1'b0);  // R9 auto width narrow

      repeat (5) @(negedge clk);
      if (!ended) begin
         ended = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule